// File: doc/BRIEF.md
# Video Processor Control Port Decoder

This block sits behind the two host-facing ports of a tile-based video display processor. Each host write on the control port is either a register write or one half of a two-word access command. Each host write on the data port is turned into a write strobe for one of three target memories: video RAM, colour RAM or scroll RAM. The strobe carries the target, the address and the data. The block holds a 6-bit access code, a 16-bit access address, a latched copy of that address, a flag that says whether a second command word is expected, and a file of 8-bit configuration registers.

Register writes are not isolated from the access state. They load the low code bits and the low address bits exactly as a first command word does. A first command word takes its upper address bits from the copy captured at the last second word. It does not take them from the live address, which data writes may have advanced since then.

After every accepted data write the live address advances by the value held in configuration register 15. DMA, reads, FIFO timing and the memories themselves sit outside this block.

Top module: `vdp_port_decoder`

## Requirements
- R1: After reset the access code, access address, address latch, pending flag and every configuration register are zero, and neither `mem_we` nor `reg_wr_pulse` is asserted.
- R2: A control word with bits 15:14 equal to 2'b10, written while no second word is pending, stores bits 7:0 into the register selected by bits 12:8. On the next cycle `reg_wr_pulse` is high for one cycle and `reg_wr_idx` holds the index.
- R3: A register write also loads code bits 1:0 from word bits 15:14 and address bits 13:0 from word bits 13:0. Code bits 5:2 are left unchanged and address bits 15:14 come from the latch. The pending flag stays clear.
- R4: Any other control word written while no second word is pending is a first command word. It loads code bits 1:0 and address bits 13:0 in the same way as R3, and then sets the pending flag.
- R5: A control word written while the pending flag is set is a second command word. Its bits 7:4 load code bits 5:2, its bits 1:0 load address bits 15:14, and the flag is cleared.
- R6: A second command word captures the complete new 16-bit address into the latch. A later first command word or register write takes address bits 15:14 from the latch, not from the live address.
- R7: A data write is accepted when code bits 3:0 are 4'b0001, 4'b0011 or 4'b0101. On the next cycle `mem_we` is high, `mem_sel` reads 0, 1 or 2 respectively (video, colour, scroll), `mem_addr` holds the address before the increment and `mem_data` holds the written word.
- R8: Each accepted data write adds configuration register 15, zero-extended, to the access address modulo 2^16.
- R9: A data write under any other code value produces no strobe and leaves the access address unchanged.
- R10: Any data write clears the pending flag, so the next control word is decoded as a first word or a register write.
- R11: When a control write and a data write arrive in the same cycle, the control write is processed and the data write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control port write this cycle |
| data_we | input | 1 | Data port write this cycle |
| wr_data | input | 16 | Word written on either port |
| mem_we | output | 1 | Target memory write strobe |
| mem_sel | output | 2 | Target: 0 video RAM, 1 colour RAM, 2 scroll RAM |
| mem_addr | output | 16 | Target memory address |
| mem_data | output | 16 | Target memory write data |
| reg_wr_pulse | output | 1 | One-cycle pulse after each register write |
| reg_wr_idx | output | 5 | Index of the register last written |
| reg_file | output | 256 | All configuration registers, register i at bits 8i+7:8i |
| acc_code | output | 6 | Current access code |
| acc_addr | output | 16 | Current access address |

## Verification
Every result is registered once. A port write sampled at one rising edge is visible on `mem_*`, `reg_wr_*`, `reg_file`, `acc_code` and `acc_addr` straight after that edge, and `reg_wr_pulse` falls one cycle later. The bench drives inputs on falling edges and also samples outputs on falling edges, so every check falls half a cycle after the edge that produced its result. A driver model queues each expected memory strobe at the moment it issues the data write. A monitor pops that entry at the first falling edge that shows `mem_we`, so any strobe that is missing, extra or late shows up as a mismatch or as a leftover entry.

// File: rtl/vdp_port_decoder.sv
module vdp_port_decoder #(
  parameter int NREGS   = 32,
  parameter int INC_REG = 15,
  localparam int RIW    = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic               data_we,
  input  logic [15:0]        wr_data,
  output logic               mem_we,
  output logic [1:0]         mem_sel,
  output logic [15:0]        mem_addr,
  output logic [15:0]        mem_data,
  output logic               reg_wr_pulse,
  output logic [RIW-1:0]     reg_wr_idx,
  output logic [NREGS*8-1:0] reg_file,
  output logic [5:0]         acc_code,
  output logic [15:0]        acc_addr
);

  logic [7:0]  regs [NREGS];
  logic        pend;
  logic [15:0] addr_latch;
  logic        tgt_ok;
  logic [1:0]  tgt;

  wire is_reg = !pend && (wr_data[15:14] == 2'b10);

  always_comb begin
    tgt_ok = 1'b1;
    tgt    = 2'd0;
    case (acc_code[3:0])
      4'b0001: tgt = 2'd0;
      4'b0011: tgt = 2'd1;
      4'b0101: tgt = 2'd2;
      default: tgt_ok = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_out
    assign reg_file[i*8 +: 8] = regs[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      pend         <= 1'b0;
      addr_latch   <= '0;
      acc_code     <= '0;
      acc_addr     <= '0;
      mem_we       <= 1'b0;
      mem_sel      <= '0;
      mem_addr     <= '0;
      mem_data     <= '0;
      reg_wr_pulse <= 1'b0;
      reg_wr_idx   <= '0;
    end else begin
      mem_we       <= 1'b0;
      reg_wr_pulse <= 1'b0;
      if (ctrl_we) begin
        if (pend) begin
          acc_code[5:2]  <= wr_data[7:4];
          acc_addr[15:14] <= wr_data[1:0];
          addr_latch     <= {wr_data[1:0], acc_addr[13:0]};
          pend           <= 1'b0;
        end else begin
          acc_code[1:0] <= wr_data[15:14];
          acc_addr      <= {addr_latch[15:14], wr_data[13:0]};
          if (is_reg) begin
            regs[wr_data[8 +: RIW]] <= wr_data[7:0];
            reg_wr_idx              <= wr_data[8 +: RIW];
            reg_wr_pulse            <= 1'b1;
          end else begin
            pend <= 1'b1;
          end
        end
      end else if (data_we) begin
        pend <= 1'b0;
        if (tgt_ok) begin
          mem_we   <= 1'b1;
          mem_sel  <= tgt;
          mem_addr <= acc_addr;
          mem_data <= wr_data;
          acc_addr <= acc_addr + {8'd0, regs[INC_REG]};
        end
      end
    end
  end

endmodule

// File: rtl/vdp_port_decoder_chk.sv
module vdp_port_decoder_chk #(
  parameter int NREGS   = 32,
  parameter int INC_REG = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctrl_we,
  input logic               data_we,
  input logic [15:0]        wr_data,
  input logic               mem_we,
  input logic [15:0]        mem_addr,
  input logic               reg_wr_pulse,
  input logic [NREGS*8-1:0] reg_file,
  input logic [5:0]         acc_code,
  input logic [15:0]        acc_addr,
  input logic               pend
);

  wire [7:0] inc = reg_file[INC_REG*8 +: 8];
  wire code_ok = (acc_code[3:0] == 4'b0001) || (acc_code[3:0] == 4'b0011) ||
                 (acc_code[3:0] == 4'b0101);
  wire lone_data = data_we && !ctrl_we;

  // R7
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(lone_data));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_data && code_ok) |=> mem_we && mem_addr == $past(acc_addr) &&
      acc_addr == $past(acc_addr) + {8'd0, $past(inc)});

  // R9
  drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_data && !code_ok) |=> !mem_we && $stable(acc_addr));

  // R3
  regwr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !pend && wr_data[15:14] == 2'b10) |=>
      reg_wr_pulse && !pend && acc_code[5:2] == $past(acc_code[5:2]));

  // R5
  second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && pend) |=> !pend && acc_addr[15:14] == $past(wr_data[1:0]) &&
      acc_code[5:2] == $past(wr_data[7:4]));

  // R10
  data_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lone_data |=> !pend);

  // R11
  ctrl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && data_we) |=> !mem_we);

endmodule

bind vdp_port_decoder vdp_port_decoder_chk #(.NREGS(NREGS), .INC_REG(INC_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .data_we(data_we), .wr_data(wr_data),
  .mem_we(mem_we), .mem_addr(mem_addr), .reg_wr_pulse(reg_wr_pulse),
  .reg_file(reg_file), .acc_code(acc_code), .acc_addr(acc_addr), .pend(pend)
);

// File: tb/vdp_port_decoder_bench.sv
module vdp_port_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0, data_we = 1'b0;
  logic [15:0] wr_data = '0;
  logic mem_we, reg_wr_pulse;
  logic [1:0] mem_sel;
  logic [15:0] mem_addr, mem_data, acc_addr;
  logic [4:0] reg_wr_idx;
  logic [255:0] reg_file;
  logic [5:0] acc_code;

  always #5 clk = ~clk;

  vdp_port_decoder u_vdp_port_decoder (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .data_we(data_we), .wr_data(wr_data),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_data(mem_data),
    .reg_wr_pulse(reg_wr_pulse), .reg_wr_idx(reg_wr_idx), .reg_file(reg_file),
    .acc_code(acc_code), .acc_addr(acc_addr)
  );

  int total = 0, bad = 0;
  logic [33:0] expq [$];

  logic [5:0]  m_code = '0;
  logic [15:0] m_addr = '0, m_latch = '0;
  logic        m_pend = 1'b0;
  logic [7:0]  m_regs [32];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_ctrl(input logic [15:0] v);
    if (m_pend) begin
      m_code[5:2] = v[7:4];
      m_addr[15:14] = v[1:0];
      m_latch = m_addr;
      m_pend = 1'b0;
    end else begin
      m_code[1:0] = v[15:14];
      m_addr = {m_latch[15:14], v[13:0]};
      if (v[15:14] == 2'b10) m_regs[v[12:8]] = v[7:0];
      else m_pend = 1'b1;
    end
  endtask

  task automatic ctrl_wr(input logic [15:0] v);
    model_ctrl(v);
    ctrl_we = 1'b1; wr_data = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic data_wr(input logic [15:0] v);
    logic [1:0] s;
    logic ok;
    ok = 1'b1; s = 2'd0;
    case (m_code[3:0])
      4'b0001: s = 2'd0;
      4'b0011: s = 2'd1;
      4'b0101: s = 2'd2;
      default: ok = 1'b0;
    endcase
    if (ok) begin
      expq.push_back({s, m_addr, v});
      m_addr = m_addr + {8'd0, m_regs[15]};
    end
    m_pend = 1'b0;
    data_we = 1'b1; wr_data = v;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic state_chk(input string tag);
    chk({tag, " code"}, acc_code, m_code);
    chk({tag, " addr"}, acc_addr, m_addr);
    for (int i = 0; i < 32; i++)
      if (reg_file[i*8 +: 8] !== m_regs[i]) chk({tag, " regfile"}, reg_file[i*8 +: 8], m_regs[i]);
  endtask

  // scoreboard monitor for R7/R8
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (expq.size() == 0) chk("R7/R9 unexpected strobe", {mem_sel, mem_addr, mem_data}, 0);
      else chk("R7/R8 strobe", {mem_sel, mem_addr, mem_data}, expq.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    state_chk("R1 reset");
    chk("R1 strobes", {mem_we, reg_wr_pulse}, 0);

    // R2 register write with pulse
    ctrl_wr(16'h8F02);
    chk("R2 pulse", reg_wr_pulse, 1);
    chk("R2 idx", reg_wr_idx, 15);
    // R3 code/address loaded by register write
    state_chk("R3 regwr");
    @(negedge clk);
    chk("R2 pulse drop", reg_wr_pulse, 0);

    // R4 R5 video RAM command, three writes
    ctrl_wr(16'h4000);
    state_chk("R4 first");
    ctrl_wr(16'h0000);
    state_chk("R5 second");
    data_wr(16'hAAA1); data_wr(16'hAAA2); data_wr(16'hAAA3);
    state_chk("R8 inc");

    // R8 wrap, R6 latch
    ctrl_wr(16'h8F20);
    ctrl_wr(16'h7FF0);
    ctrl_wr(16'h0003);
    state_chk("R6 latch set");
    data_wr(16'hB001); data_wr(16'hB002);
    state_chk("R8 wrap");
    ctrl_wr(16'h4004);
    chk("R6 latched upper", acc_addr, 16'hC004);
    ctrl_wr(16'h0000);
    data_wr(16'hB003);

    // R7 colour and scroll targets
    ctrl_wr(16'hC000); ctrl_wr(16'h0000);
    data_wr(16'hC0C0);
    ctrl_wr(16'h4000); ctrl_wr(16'h0010);
    state_chk("R7 scroll code");
    data_wr(16'h5C5C);

    // R3 upper code kept, R9 discard
    ctrl_wr(16'h8F04);
    chk("R3 keep upper code", acc_code, 6'b000110);
    data_wr(16'hDEAD);
    @(negedge clk);
    state_chk("R9 discarded");

    // R10 data write clears pending
    ctrl_wr(16'h4100);
    data_wr(16'h1234);
    ctrl_wr(16'h8A55);
    chk("R10 reg10", reg_file[10*8 +: 8], 8'h55);
    state_chk("R10 state");

    // R11 control wins
    ctrl_wr(16'h8F02);
    model_ctrl(16'h4200);
    ctrl_we = 1'b1; data_we = 1'b1; wr_data = 16'h4200;
    @(negedge clk);
    ctrl_we = 1'b0; data_we = 1'b0;
    chk("R11 no strobe", mem_we, 0);
    state_chk("R11 state");
    ctrl_wr(16'h0010);

    // R9 read code
    ctrl_wr(16'h0000); ctrl_wr(16'h0000);
    data_wr(16'hFFFF);
    @(negedge clk);
    state_chk("R9 read code");

    repeat (2) @(negedge clk);
    chk("R7 queue drained", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule